// File: doc/BRIEF.md
# Pipelined Keyed 16-bit Nonlinear Function

This block computes a keyed nonlinear mapping of a 16-bit word. It is built from two unequal substitutions, a 9-bit one and a 7-bit one. Both are written as XOR sums of AND terms over GF(2) instead of lookup tables. The word is split into a 9-bit lane and a 7-bit lane. The lanes pass through the substitutions in turn and exchange bits by zero-extension (7 to 9 bits) and truncation (9 to 7 bits, dropping the two top bits). A 16-bit subkey is mixed in at the middle. Each substitution is split into two register stages. The key is carried down a delay line to the stages that consume it.

A new operand and key pair may be presented on every clock cycle. A valid flag travels beside the data. The result appears after a fixed latency of 7 cycles, or 8 cycles when the extra output register is enabled by parameter. The block is meant to sit inside a larger round datapath or key expansion datapath that feeds it one operation per cycle.

Top module: `nlf16_pipe`

## Requirements
- R1: `out_valid` is 0 from reset until an accepted operand reaches the output. After that, `out_valid` equals `in_valid` from exactly the latency's number of cycles earlier. An operand presented while `rst` is 1 is dropped.
- R2: The latency is 7 clock edges with `EXTRA_OUT_REG` = 0 and 8 clock edges with `EXTRA_OUT_REG` = 1. The results are identical in both cases.
- R3: Let the 9-bit lane A = `in_data[15:7]`, the 7-bit lane B = `in_data[6:0]`, the key part K7 = `in_key[15:9]` and K9 = `in_key[8:0]`. The steps are: A = S9(A) ^ zext(B); B = S7(B) ^ A[6:0] ^ K7; A = A ^ K9; A = S9(A) ^ zext(B); B = S7(B) ^ A[6:0]. The output is `out_data` = {B, A}.
- R4: Operands presented on consecutive cycles are each processed independently, with no dead cycles and no interaction between them.
- R5: Both S-boxes treat polynomial variable x0 as the lane MSB and output y0 as the result MSB. Each output bit is the fixed GF(2) polynomial of the substitution. For example, S9 bit y0 = x0x4^x0x5^x1x5^x1x6^x2x6^x2x7^x3x7^x3x8^x4x8^1.
- R6: The key is used only with the operand presented in the same cycle. A key change on every cycle produces, for each operand, the result of its own key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 16 | Operand word |
| in_key | input | 16 | Subkey paired with the operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 16 | Result word |

## Verification
The hardest case to reach is a key that differs on every cycle while the pipeline is full. The key halves are consumed in two different stages, so a wrong delay on either half shows up only when neighbouring operands carry different keys. The stimulus therefore includes a phase with a fixed operand and a fresh key every cycle, a gap-free burst of random pairs, and a long random stream with idle gaps. Two instances, one of each latency, are fed the same stream so their outputs can be compared against shifted copies of the bench model.

// File: rtl/nlf16_pkg.sv
package nlf16_pkg;

    localparam int LANE_W = 9;
    localparam int LANE_N = 7;
    localparam int WORD_W = LANE_W + LANE_N;

    typedef logic [LANE_W-1:0] lane9_t;
    typedef logic [LANE_N-1:0] lane7_t;

    // operand: wide lane on top
    typedef struct packed {
        lane9_t wide;
        lane7_t narrow;
    } operand_t;

    // subkey: 7-bit part on top, mixed into the narrow lane
    typedef struct packed {
        lane7_t k7;
        lane9_t k9;
    } subkey_t;

    // result: narrow lane on top
    typedef struct packed {
        lane7_t narrow;
        lane9_t wide;
    } result_t;

    function automatic lane9_t flip9(input lane9_t v);
        lane9_t r;
        for (int i = 0; i < LANE_W; i++) r[i] = v[LANE_W-1-i];
        return r;
    endfunction

    function automatic lane7_t flip7(input lane7_t v);
        lane7_t r;
        for (int i = 0; i < LANE_N; i++) r[i] = v[LANE_N-1-i];
        return r;
    endfunction

    // first half of the S9 terms (x0 = lane MSB)
    function automatic lane9_t s9_part_a(input lane9_t v);
        lane9_t x, y;
        x = flip9(v);
        y[0] = (x[0]&x[4])^(x[0]&x[5])^(x[1]&x[5])^(x[1]&x[6])^(x[2]&x[6]);
        y[1] = (x[0]&x[2])^x[3]^(x[1]&x[3])^(x[2]&x[3])^(x[3]&x[4])^(x[4]&x[5]);
        y[2] = (x[0]&x[1])^(x[1]&x[3])^x[4]^(x[0]&x[4])^(x[2]&x[4])^(x[3]&x[4]);
        y[3] = x[0]^(x[1]&x[2])^(x[2]&x[4])^x[5]^(x[1]&x[5])^(x[3]&x[5]);
        y[4] = x[1]^(x[0]&x[3])^(x[2]&x[3])^(x[0]&x[5])^(x[3]&x[5])^x[6];
        y[5] = x[2]^(x[0]&x[3])^(x[1]&x[4])^(x[3]&x[4])^(x[1]&x[6])^(x[4]&x[6]);
        y[6] = (x[0]&x[1])^x[3]^(x[1]&x[4])^(x[2]&x[5])^(x[4]&x[5])^(x[2]&x[7]);
        y[7] = x[1]^(x[0]&x[1])^(x[1]&x[2])^(x[2]&x[3])^(x[0]&x[4])^x[5];
        y[8] = x[0]^(x[0]&x[1])^(x[1]&x[2])^x[4]^(x[0]&x[5])^(x[2]&x[5]);
        return flip9(y);
    endfunction

    // second half of the S9 terms, constants included
    function automatic lane9_t s9_part_b(input lane9_t v);
        lane9_t x, y;
        x = flip9(v);
        y[0] = (x[2]&x[7])^(x[3]&x[7])^(x[3]&x[8])^(x[4]&x[8])^1'b1;
        y[1] = (x[0]&x[6])^(x[2]&x[6])^x[7]^(x[0]&x[8])^(x[3]&x[8])^(x[5]&x[8])^1'b1;
        y[2] = (x[4]&x[5])^(x[0]&x[6])^(x[5]&x[6])^(x[1]&x[7])^(x[3]&x[7])^x[8];
        y[3] = (x[4]&x[5])^(x[5]&x[6])^(x[1]&x[7])^(x[6]&x[7])^(x[2]&x[8])^(x[4]&x[8]);
        y[4] = (x[2]&x[6])^(x[4]&x[6])^(x[5]&x[6])^(x[6]&x[7])^(x[2]&x[8])^(x[7]&x[8]);
        y[5] = x[7]^(x[3]&x[7])^(x[5]&x[7])^(x[6]&x[7])^(x[0]&x[8])^(x[7]&x[8]);
        y[6] = (x[5]&x[7])^x[8]^(x[0]&x[8])^(x[4]&x[8])^(x[6]&x[8])^(x[7]&x[8])^1'b1;
        y[7] = (x[1]&x[6])^(x[3]&x[6])^(x[0]&x[7])^(x[4]&x[7])^(x[6]&x[7])^(x[1]&x[8])^1'b1;
        y[8] = (x[3]&x[6])^(x[5]&x[6])^(x[0]&x[7])^(x[0]&x[8])^(x[3]&x[8])^(x[6]&x[8])^1'b1;
        return flip9(y);
    endfunction

    function automatic lane7_t s7_part_a(input lane7_t v);
        lane7_t x, y;
        x = flip7(v);
        y[0] = x[0]^(x[1]&x[3])^(x[0]&x[3]&x[4])^(x[1]&x[5])^(x[0]&x[2]&x[5]);
        y[1] = (x[0]&x[2])^(x[0]&x[4])^(x[3]&x[4])^(x[1]&x[5])^(x[2]&x[4]&x[5])^x[6];
        y[2] = (x[1]&x[2])^(x[0]&x[2]&x[3])^x[4]^(x[1]&x[4])^(x[0]&x[1]&x[4])^(x[0]&x[5]);
        y[3] = x[0]^x[1]^(x[0]&x[1]&x[2])^(x[0]&x[3])^(x[2]&x[4]);
        y[4] = (x[2]&x[3])^(x[0]&x[4])^(x[1]&x[3]&x[4])^x[5]^(x[2]&x[5]);
        y[5] = x[0]^x[1]^x[2]^(x[0]&x[1]&x[2])^(x[0]&x[3])^(x[1]&x[2]&x[3]);
        y[6] = (x[0]&x[1])^x[3]^(x[0]&x[3])^(x[2]&x[3]&x[4])^(x[0]&x[5])^(x[2]&x[5]);
        return flip7(y);
    endfunction

    function automatic lane7_t s7_part_b(input lane7_t v);
        lane7_t x, y;
        x = flip7(v);
        y[0] = (x[4]&x[5])^(x[0]&x[1]&x[6])^(x[2]&x[6])^(x[0]&x[5]&x[6])^(x[3]&x[5]&x[6])^1'b1;
        y[1] = (x[0]&x[6])^(x[3]&x[6])^(x[2]&x[3]&x[6])^(x[1]&x[4]&x[6])^(x[0]&x[5]&x[6])^1'b1;
        y[2] = (x[0]&x[4]&x[5])^(x[3]&x[4]&x[5])^(x[1]&x[6])^(x[3]&x[6])^(x[0]&x[3]&x[6])
             ^(x[4]&x[6])^(x[2]&x[4]&x[6]);
        y[3] = (x[1]&x[4]&x[5])^(x[2]&x[6])^(x[1]&x[3]&x[6])^(x[0]&x[4]&x[6])^(x[5]&x[6])^1'b1;
        y[4] = (x[1]&x[2]&x[5])^(x[0]&x[3]&x[5])^(x[1]&x[6])^(x[1]&x[5]&x[6])^(x[4]&x[5]&x[6])^1'b1;
        y[5] = (x[1]&x[4])^(x[0]&x[2]&x[4])^(x[0]&x[5])^(x[0]&x[1]&x[5])^(x[3]&x[5])
             ^(x[0]&x[6])^(x[2]&x[5]&x[6]);
        y[6] = (x[3]&x[5])^(x[1]&x[3]&x[5])^(x[1]&x[6])^(x[1]&x[2]&x[6])^(x[0]&x[3]&x[6])
             ^(x[4]&x[6])^(x[2]&x[5]&x[6]);
        return flip7(y);
    endfunction

    function automatic lane9_t sub9(input lane9_t v);
        return s9_part_a(v) ^ s9_part_b(v);
    endfunction

    function automatic lane7_t sub7(input lane7_t v);
        return s7_part_a(v) ^ s7_part_b(v);
    endfunction

    // unpipelined reference, used by the output assertion
    function automatic result_t nlf16_ref(input operand_t d, input subkey_t k);
        lane9_t a;
        lane7_t b;
        result_t r;
        a = sub9(d.wide) ^ {2'b00, d.narrow};
        b = sub7(d.narrow) ^ a[LANE_N-1:0] ^ k.k7;
        a = a ^ k.k9;
        a = sub9(a) ^ {2'b00, b};
        b = sub7(b) ^ a[LANE_N-1:0];
        r.narrow = b;
        r.wide   = a;
        return r;
    endfunction

endpackage

// File: rtl/nlf16_delay.sv
module nlf16_delay #(
    parameter int W = 1,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (N == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] tap [N];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < N; i++) tap[i] <= '0;
                end else begin
                    tap[0] <= d;
                    for (int i = 1; i < N; i++) tap[i] <= tap[i-1];
                end
            end
            assign q = tap[N-1];
        end
    endgenerate
endmodule

// File: rtl/nlf16_sbox.sv
module nlf16_sbox
    import nlf16_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] x,
    input  logic [W-1:0] mix,
    output logic [W-1:0] y
);
    logic [W-1:0] part_a_n, part_b_n, whole_n;
    logic [W-1:0] part_a_q, part_b_q, y_q;
    logic [1:0]   warm;

    generate
        if (W == LANE_W) begin : g_s9
            assign part_a_n = s9_part_a(x);
            assign part_b_n = s9_part_b(x);
            assign whole_n  = sub9(x);
        end else begin : g_s7
            assign part_a_n = s7_part_a(x);
            assign part_b_n = s7_part_b(x);
            assign whole_n  = sub7(x);
        end
    endgenerate

    // stage one holds two partial sums, stage two folds them with mix
    always_ff @(posedge clk) begin
        if (rst) begin
            part_a_q <= '0;
            part_b_q <= '0;
            y_q      <= '0;
        end else begin
            part_a_q <= part_a_n;
            part_b_q <= part_b_n;
            y_q      <= part_a_q ^ part_b_q ^ mix;
        end
    end
    assign y = y_q;

    always_ff @(posedge clk) begin
        if (rst)            warm <= '0;
        else if (warm != 2) warm <= warm + 2'd1;
    end

    // R5
    sbox_poly_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> (y == ($past(whole_n, 2) ^ $past(mix))));
endmodule

// File: rtl/nlf16_pipe.sv
module nlf16_pipe
    import nlf16_pkg::*;
#(
    parameter bit EXTRA_OUT_REG = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    input  logic [15:0] in_key,
    output logic        out_valid,
    output logic [15:0] out_data
);
    localparam int CORE_LAT = 7;
    localparam int LAT      = CORE_LAT + (EXTRA_OUT_REG ? 1 : 0);
    localparam logic [3:0] LAT4 = 4'(LAT);

    // stage 1: capture
    logic     s1_v;
    operand_t s1_d;
    subkey_t  s1_k;
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_d <= '0;
            s1_k <= '0;
        end else begin
            s1_v <= in_valid;
            s1_d <= operand_t'(in_data);
            s1_k <= subkey_t'(in_key);
        end
    end

    lane7_t  nar_2, nar_3;
    subkey_t key_3;
    lane7_t  k7_4;
    lane9_t  a9_3, a9_4, c9raw_5, c9_7;
    lane7_t  b7_5, e7_7;
    lane9_t  c9_6;
    logic    v_7;

    nlf16_delay #(.W(LANE_N), .N(1)) u_nar2 (.clk(clk), .rst(rst), .d(s1_d.narrow), .q(nar_2));
    nlf16_delay #(.W(LANE_N), .N(1)) u_nar3 (.clk(clk), .rst(rst), .d(nar_2), .q(nar_3));
    nlf16_delay #(.W(WORD_W), .N(2)) u_key3 (.clk(clk), .rst(rst), .d(s1_k), .q(key_3));
    nlf16_delay #(.W(LANE_N), .N(1)) u_k7_4 (.clk(clk), .rst(rst), .d(key_3.k7), .q(k7_4));
    nlf16_delay #(.W(LANE_W), .N(1)) u_a9_4 (.clk(clk), .rst(rst), .d(a9_3), .q(a9_4));
    nlf16_delay #(.W(1), .N(CORE_LAT-1)) u_vld (.clk(clk), .rst(rst), .d(s1_v), .q(v_7));

    // stages 2-3: first wide substitution, narrow lane folded in
    nlf16_sbox #(.W(LANE_W)) u_s9_first (
        .clk(clk), .rst(rst), .x(s1_d.wide), .mix({2'b00, nar_2}), .y(a9_3));

    // stages 4-5: first narrow substitution with key, in parallel with second wide one
    nlf16_sbox #(.W(LANE_N)) u_s7_first (
        .clk(clk), .rst(rst), .x(nar_3), .mix(a9_4[LANE_N-1:0] ^ k7_4), .y(b7_5));
    nlf16_sbox #(.W(LANE_W)) u_s9_second (
        .clk(clk), .rst(rst), .x(a9_3 ^ key_3.k9), .mix('0), .y(c9raw_5));

    // stage 6: zero-extended narrow lane joins the wide lane
    always_ff @(posedge clk) begin
        if (rst) c9_6 <= '0;
        else     c9_6 <= c9raw_5 ^ {2'b00, b7_5};
    end

    // stages 6-7: second narrow substitution, truncated wide lane folded in
    nlf16_sbox #(.W(LANE_N)) u_s7_second (
        .clk(clk), .rst(rst), .x(b7_5), .mix(c9_6[LANE_N-1:0]), .y(e7_7));
    nlf16_delay #(.W(LANE_W), .N(1)) u_c9_7 (.clk(clk), .rst(rst), .d(c9_6), .q(c9_7));

    result_t core_res;
    assign core_res.narrow = e7_7;
    assign core_res.wide   = c9_7;

    generate
        if (EXTRA_OUT_REG) begin : g_outreg
            logic    ov_q;
            result_t od_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ov_q <= 1'b0;
                    od_q <= '0;
                end else begin
                    ov_q <= v_7;
                    od_q <= core_res;
                end
            end
            assign out_valid = ov_q;
            assign out_data  = od_q;
        end else begin : g_direct
            assign out_valid = v_7;
            assign out_data  = core_res;
        end
    endgenerate

    logic [3:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != LAT4) since_rst <= since_rst + 4'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
    // R1 R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == LAT4) |-> (out_valid == $past(in_valid, LAT)));
    // R3 R6
    result_value_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == LAT4 && out_valid) |->
        (out_data == $past(nlf16_ref(operand_t'(in_data), subkey_t'(in_key)), LAT)));
endmodule

// File: tb/nlf16_pipe_tb.sv
module nlf16_pipe_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        in_valid;
    logic [15:0] in_data, in_key;
    logic        ov_a, ov_b;
    logic [15:0] od_a, od_b;

    nlf16_pipe #(.EXTRA_OUT_REG(1'b0)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_key(in_key), .out_valid(ov_a), .out_data(od_a));
    nlf16_pipe #(.EXTRA_OUT_REG(1'b1)) u_dut_x (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_key(in_key), .out_valid(ov_b), .out_data(od_b));

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    logic        hv [1024];
    logic [15:0] hd [1024];
    logic [15:0] hk [1024];
    int          ht [1024];

    function automatic logic [8:0] r9(input logic [8:0] v);
        logic [8:0] o;
        for (int i = 0; i < 9; i++) o[i] = v[8-i];
        return o;
    endfunction
    function automatic logic [6:0] r7(input logic [6:0] v);
        logic [6:0] o;
        for (int i = 0; i < 7; i++) o[i] = v[6-i];
        return o;
    endfunction

    function automatic logic [8:0] m9(input logic [8:0] v);
        logic [8:0] x, y;
        x = r9(v);
        y[0] = x[0]&x[4]^x[0]&x[5]^x[1]&x[5]^x[1]&x[6]^x[2]&x[6]^x[2]&x[7]^x[3]&x[7]^x[3]&x[8]^x[4]&x[8]^1;
        y[1] = x[0]&x[2]^x[3]^x[1]&x[3]^x[2]&x[3]^x[3]&x[4]^x[4]&x[5]^x[0]&x[6]^x[2]&x[6]^x[7]^x[0]&x[8]^x[3]&x[8]^x[5]&x[8]^1;
        y[2] = x[0]&x[1]^x[1]&x[3]^x[4]^x[0]&x[4]^x[2]&x[4]^x[3]&x[4]^x[4]&x[5]^x[0]&x[6]^x[5]&x[6]^x[1]&x[7]^x[3]&x[7]^x[8];
        y[3] = x[0]^x[1]&x[2]^x[2]&x[4]^x[5]^x[1]&x[5]^x[3]&x[5]^x[4]&x[5]^x[5]&x[6]^x[1]&x[7]^x[6]&x[7]^x[2]&x[8]^x[4]&x[8];
        y[4] = x[1]^x[0]&x[3]^x[2]&x[3]^x[0]&x[5]^x[3]&x[5]^x[6]^x[2]&x[6]^x[4]&x[6]^x[5]&x[6]^x[6]&x[7]^x[2]&x[8]^x[7]&x[8];
        y[5] = x[2]^x[0]&x[3]^x[1]&x[4]^x[3]&x[4]^x[1]&x[6]^x[4]&x[6]^x[7]^x[3]&x[7]^x[5]&x[7]^x[6]&x[7]^x[0]&x[8]^x[7]&x[8];
        y[6] = x[0]&x[1]^x[3]^x[1]&x[4]^x[2]&x[5]^x[4]&x[5]^x[2]&x[7]^x[5]&x[7]^x[8]^x[0]&x[8]^x[4]&x[8]^x[6]&x[8]^x[7]&x[8]^1;
        y[7] = x[1]^x[0]&x[1]^x[1]&x[2]^x[2]&x[3]^x[0]&x[4]^x[5]^x[1]&x[6]^x[3]&x[6]^x[0]&x[7]^x[4]&x[7]^x[6]&x[7]^x[1]&x[8]^1;
        y[8] = x[0]^x[0]&x[1]^x[1]&x[2]^x[4]^x[0]&x[5]^x[2]&x[5]^x[3]&x[6]^x[5]&x[6]^x[0]&x[7]^x[0]&x[8]^x[3]&x[8]^x[6]&x[8]^1;
        return r9(y);
    endfunction

    function automatic logic [6:0] m7(input logic [6:0] v);
        logic [6:0] x, y;
        x = r7(v);
        y[0] = x[0]^x[1]&x[3]^x[0]&x[3]&x[4]^x[1]&x[5]^x[0]&x[2]&x[5]^x[4]&x[5]^x[0]&x[1]&x[6]^x[2]&x[6]^x[0]&x[5]&x[6]^x[3]&x[5]&x[6]^1;
        y[1] = x[0]&x[2]^x[0]&x[4]^x[3]&x[4]^x[1]&x[5]^x[2]&x[4]&x[5]^x[6]^x[0]&x[6]^x[3]&x[6]^x[2]&x[3]&x[6]^x[1]&x[4]&x[6]^x[0]&x[5]&x[6]^1;
        y[2] = x[1]&x[2]^x[0]&x[2]&x[3]^x[4]^x[1]&x[4]^x[0]&x[1]&x[4]^x[0]&x[5]^x[0]&x[4]&x[5]^x[3]&x[4]&x[5]^x[1]&x[6]^x[3]&x[6]^x[0]&x[3]&x[6]^x[4]&x[6]^x[2]&x[4]&x[6];
        y[3] = x[0]^x[1]^x[0]&x[1]&x[2]^x[0]&x[3]^x[2]&x[4]^x[1]&x[4]&x[5]^x[2]&x[6]^x[1]&x[3]&x[6]^x[0]&x[4]&x[6]^x[5]&x[6]^1;
        y[4] = x[2]&x[3]^x[0]&x[4]^x[1]&x[3]&x[4]^x[5]^x[2]&x[5]^x[1]&x[2]&x[5]^x[0]&x[3]&x[5]^x[1]&x[6]^x[1]&x[5]&x[6]^x[4]&x[5]&x[6]^1;
        y[5] = x[0]^x[1]^x[2]^x[0]&x[1]&x[2]^x[0]&x[3]^x[1]&x[2]&x[3]^x[1]&x[4]^x[0]&x[2]&x[4]^x[0]&x[5]^x[0]&x[1]&x[5]^x[3]&x[5]^x[0]&x[6]^x[2]&x[5]&x[6];
        y[6] = x[0]&x[1]^x[3]^x[0]&x[3]^x[2]&x[3]&x[4]^x[0]&x[5]^x[2]&x[5]^x[3]&x[5]^x[1]&x[3]&x[5]^x[1]&x[6]^x[1]&x[2]&x[6]^x[0]&x[3]&x[6]^x[4]&x[6]^x[2]&x[5]&x[6];
        return r7(y);
    endfunction

    function automatic logic [15:0] model(input logic [15:0] d, input logic [15:0] k);
        logic [8:0] wa;
        logic [6:0] nb;
        wa = m9(d[15:7]) ^ {2'b00, d[6:0]};
        nb = m7(d[6:0]) ^ wa[6:0] ^ k[15:9];
        wa = wa ^ k[8:0];
        wa = m9(wa) ^ {2'b00, nb};
        nb = m7(nb) ^ wa[6:0];
        return {nb, wa};
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic compare_lane(input int lat, input logic av, input logic [15:0] ad);
        int  idx;
        logic ev;
        string vt;
        idx = cyc - lat;
        ev  = (idx >= 0) ? hv[idx % 1024] : 1'b0;
        vt  = (lat == 7) ? "R1" : "R2";
        checks++;
        if (av !== ev) begin
            fails++;
            $display("FAIL %s valid lat=%0d cyc=%0d: actual=%0b expected=%0b", vt, lat, cyc, av, ev);
        end
        if (ev) begin
            logic [15:0] ex;
            ex = model(hd[idx % 1024], hk[idx % 1024]);
            checks++;
            if (ad !== ex) begin
                fails++;
                $display("FAIL %s data lat=%0d cyc=%0d: actual=%h expected=%h",
                         tag_name(ht[idx % 1024]), lat, cyc, ad, ex);
            end
        end
    endtask

    task automatic step(input bit r, input bit v, input logic [15:0] d,
                        input logic [15:0] k, input int t);
        @(negedge clk);
        compare_lane(7, ov_a, od_a);
        compare_lane(8, ov_b, od_b);
        rst      = r;
        in_valid = v;
        in_data  = d;
        in_key   = k;
        hv[cyc % 1024] = v & !r;
        hd[cyc % 1024] = d;
        hk[cyc % 1024] = k;
        ht[cyc % 1024] = t;
        cyc++;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            hv[i] = 1'b0; hd[i] = '0; hk[i] = '0; ht[i] = 3;
        end
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_key = '0;
        void'($urandom(32'd2024));
        // R1: operands during reset are dropped
        step(1, 0, 16'h0000, 16'h0000, 3);
        step(1, 1, 16'hBEEF, 16'h1234, 3);
        step(1, 1, 16'h5A5A, 16'hA5A5, 3);
        step(1, 0, 16'h0000, 16'h0000, 3);
        // R5: directed polynomial corners, zero-extension and truncation
        step(0, 1, 16'h0000, 16'h0000, 5);
        step(0, 1, 16'hFFFF, 16'hFFFF, 5);
        step(0, 1, 16'hFF80, 16'h0000, 5);
        step(0, 1, 16'h007F, 16'h0000, 5);
        step(0, 1, 16'h0000, 16'hFE00, 5);
        step(0, 1, 16'h0000, 16'h01FF, 5);
        for (int i = 0; i < 9; i++) step(0, 1, 16'h0080 << i, 16'h0000, 5);
        // R6: same operand, fresh key every cycle
        for (int i = 0; i < 40; i++) step(0, 1, 16'h1234, 16'($urandom), 6);
        step(0, 0, 16'h0000, 16'h0000, 6);
        // R4: gap-free burst
        for (int i = 0; i < 200; i++) step(0, 1, 16'($urandom), 16'($urandom), 4);
        // R3: random stream with idle gaps
        for (int i = 0; i < 4000; i++)
            step(0, ($urandom % 10) < 7, 16'($urandom), 16'($urandom), 3);
        for (int i = 0; i < 12; i++) step(0, 0, 16'h0000, 16'h0000, 3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule